// File: doc/BRIEF.md
# Encoded Status Bus Command Decoder

This block sits next to a processor that runs its external bus in maximum mode. In that mode the processor does not drive separate bus strobes. It puts a 3-bit status code on its status pins instead, and an external controller must turn that code into bus commands. The decoder samples the code on every rising clock edge. It treats a move away from the all-ones idle code as the start of a bus cycle. It then produces an address latch pulse, one command strobe that matches the cycle type, a transceiver enable, and a transceiver direction signal.

A cycle runs as follows. The processor drives a non-idle code at the end of the previous cycle. The decoder answers with a one-clock latch pulse, and then raises the matching strobe. The strobe stays high until the decoder samples the idle code again. A halt code still gives the latch pulse but no strobe. The cycle type is captured at the start, so codes that change while a cycle is running have no effect until that cycle is over. All outputs are registered, active high and cleared by a synchronous reset.

Top module: `status_cmd_decoder`

## Requirements
- R1: A synchronous reset clears every output to 0 on the edge where it is sampled. All outputs stay 0 while reset is held.
- R2: A start is recognised only while no cycle is running, and only when the code sampled at an edge is not 111 and the code sampled at the previous edge was 111. After that edge, `ale_o` is high for exactly one clock.
- R3: On the edge after the latch pulse, exactly one strobe goes high. Code 101 (memory read) and code 100 (code fetch) both select `mem_rd_o`. Code 110 selects `mem_wr_o`. Code 001 selects `io_rd_o`. Code 010 selects `io_wr_o`. Code 000 selects `inta_o`.
- R4: A strobe stays high until the first edge that samples code 111, and falls on that edge. The strobe is high for at least one clock even if the idle code already returned during the latch pulse.
- R5: Code 011 (halt) produces the latch pulse but no strobe, and `den_o` stays low. The halt cycle ends at the first edge that samples 111.
- R6: The cycle type is captured at the start edge. Codes sampled later in the same cycle are ignored, even when they are not 111, and they do not start a new cycle.
- R7: `den_o` is high exactly in the clocks where a strobe is high.
- R8: `dt_tx_o` is high from the latch pulse to the end of the strobe for cycles with code 110 or 010. It is low for reads, fetches, interrupt acknowledge and halt, and low while no cycle runs.
- R9: At most one strobe is high at any time.
- R10: A new cycle can start on the edge right after the one where a strobe fell. Its latch pulse then comes one clock after the old strobe falls, and never overlaps it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | 3 | Encoded bus status from the processor; 111 means idle |
| ale_o | output | 1 | Address latch pulse, one clock per cycle |
| mem_rd_o | output | 1 | Memory read strobe (also used for code fetch) |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| den_o | output | 1 | Data transceiver enable, high along with a strobe |
| dt_tx_o | output | 1 | Transceiver direction: 1 drives data out (write), 0 receives |

## Verification
Two events can meet at the border between cycles: a strobe falling, and the start of the next cycle. The bench drives 111 for exactly one clock after a command and then a new code at once. It checks that the strobe falls on the edge that samples the idle code, and that the next latch pulse comes on the very next edge with no overlap. A second meeting point is a code change that arrives while a strobe is still high. The bench swaps the code mid-cycle with no idle gap in between. It checks that the strobe of the original type holds unchanged and that no new latch pulse appears.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  localparam int STW  = 3;
  localparam int NCMD = 5;

  // Strobe slot indices inside the command vector
  localparam int CI_MRD  = 0;
  localparam int CI_MWR  = 1;
  localparam int CI_IORD = 2;
  localparam int CI_IOWR = 3;
  localparam int CI_INTA = 4;

  typedef enum logic [STW-1:0] {
    SC_INTA  = 3'b000,
    SC_IORD  = 3'b001,
    SC_IOWR  = 3'b010,
    SC_HALT  = 3'b011,
    SC_FETCH = 3'b100,
    SC_MRD   = 3'b101,
    SC_MWR   = 3'b110,
    SC_IDLE  = 3'b111
  } bus_code_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ALE,
    PH_CMD,
    PH_HALT
  } phase_e;

  function automatic logic [NCMD-1:0] cmd_onehot(input bus_code_e c);
    logic [NCMD-1:0] v;
    v = '0;
    case (c)
      SC_MRD, SC_FETCH: v[CI_MRD]  = 1'b1;
      SC_MWR:           v[CI_MWR]  = 1'b1;
      SC_IORD:          v[CI_IORD] = 1'b1;
      SC_IOWR:          v[CI_IOWR] = 1'b1;
      SC_INTA:          v[CI_INTA] = 1'b1;
      default:          v = '0;
    endcase
    return v;
  endfunction

  function automatic logic code_writes(input bus_code_e c);
    return (c == SC_MWR) || (c == SC_IOWR);
  endfunction

endpackage

// File: rtl/sbd_status_sampler.sv
module sbd_status_sampler #(
  parameter int               W         = 3,
  parameter logic [W-1:0]     IDLE_CODE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_i,
  input  logic         armed_i,
  output logic         start_o,
  output logic         passive_o
);

  logic prev_idle_q;

  assign passive_o = (status_i == IDLE_CODE);

  // The previous sample is taken to be idle out of reset
  always_ff @(posedge clk) begin
    if (rst) prev_idle_q <= 1'b1;
    else     prev_idle_q <= passive_o;
  end

  assign start_o = armed_i & prev_idle_q & ~passive_o;

endmodule

// File: rtl/sbd_cycle_fsm.sv
module sbd_cycle_fsm
  import sbd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      passive_i,
  input  bus_code_e code_i,
  output logic      armed_o,
  output phase_e    phase_nxt_o,
  output bus_code_e kind_nxt_o
);

  phase_e    phase_q;
  bus_code_e kind_q;

  always_comb begin
    phase_nxt_o = phase_q;
    kind_nxt_o  = kind_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_nxt_o = PH_ALE;
        kind_nxt_o  = code_i;
      end
      PH_ALE:  phase_nxt_o = (kind_q == SC_HALT) ? PH_HALT : PH_CMD;
      PH_CMD:  if (passive_i) phase_nxt_o = PH_IDLE;
      PH_HALT: if (passive_i) phase_nxt_o = PH_IDLE;
      default: phase_nxt_o = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      kind_q  <= SC_IDLE;
    end else begin
      phase_q <= phase_nxt_o;
      kind_q  <= kind_nxt_o;
    end
  end

  assign armed_o = (phase_q == PH_IDLE);

endmodule

// File: rtl/sbd_strobe_gen.sv
module sbd_strobe_gen
  import sbd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  phase_e          phase_i,
  input  bus_code_e       kind_i,
  output logic            ale_o,
  output logic [NCMD-1:0] cmd_o,
  output logic            den_o,
  output logic            dt_tx_o
);

  logic [NCMD-1:0] sel;
  logic            in_cmd;
  logic            in_cycle;

  assign sel      = cmd_onehot(kind_i);
  assign in_cmd   = (phase_i == PH_CMD);
  assign in_cycle = (phase_i != PH_IDLE);

  for (genvar i = 0; i < NCMD; i++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) cmd_o[i] <= 1'b0;
      else     cmd_o[i] <= in_cmd & sel[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o   <= 1'b0;
      den_o   <= 1'b0;
      dt_tx_o <= 1'b0;
    end else begin
      ale_o   <= (phase_i == PH_ALE);
      den_o   <= in_cmd & (|sel);
      dt_tx_o <= in_cycle & code_writes(kind_i);
    end
  end

endmodule

// File: rtl/status_cmd_decoder.sv
module status_cmd_decoder
  import sbd_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [STW-1:0] status_i,
  output logic           ale_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           io_rd_o,
  output logic           io_wr_o,
  output logic           inta_o,
  output logic           den_o,
  output logic           dt_tx_o
);

  logic            start;
  logic            passive;
  logic            armed;
  phase_e          phase_nxt;
  bus_code_e       kind_nxt;
  logic [NCMD-1:0] cmd;

  sbd_status_sampler #(
    .W         (STW),
    .IDLE_CODE (SC_IDLE)
  ) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .status_i  (status_i),
    .armed_i   (armed),
    .start_o   (start),
    .passive_o (passive)
  );

  sbd_cycle_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .passive_i   (passive),
    .code_i      (bus_code_e'(status_i)),
    .armed_o     (armed),
    .phase_nxt_o (phase_nxt),
    .kind_nxt_o  (kind_nxt)
  );

  sbd_strobe_gen u_strobe (
    .clk     (clk),
    .rst     (rst),
    .phase_i (phase_nxt),
    .kind_i  (kind_nxt),
    .ale_o   (ale_o),
    .cmd_o   (cmd),
    .den_o   (den_o),
    .dt_tx_o (dt_tx_o)
  );

  assign mem_rd_o = cmd[CI_MRD];
  assign mem_wr_o = cmd[CI_MWR];
  assign io_rd_o  = cmd[CI_IORD];
  assign io_wr_o  = cmd[CI_IOWR];
  assign inta_o   = cmd[CI_INTA];

endmodule

// File: rtl/status_cmd_decoder_chk.sv
module status_cmd_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] status_i,
  input logic       ale_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       io_rd_o,
  input logic       io_wr_o,
  input logic       inta_o,
  input logic       den_o,
  input logic       dt_tx_o
);

  logic [4:0] strb;
  logic       rst_d;

  assign strb = {inta_o, io_wr_o, io_rd_o, mem_wr_o, mem_rd_o};

  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs clear on an edge that sampled reset
  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_clear_r1: assert ({ale_o, strb, den_o, dt_tx_o} == 8'b0)
        else $error("reset did not clear outputs");
    end
  end

  p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
    ale_o |=> !ale_o);

  p_strobe_after_ale_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(|strb) |-> $past(ale_o));

  p_drop_on_idle_r4: assert property (@(posedge clk) disable iff (rst)
    ((|strb) && status_i == 3'b111) |=> !(|strb));

  p_halt_no_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    (ale_o && $past(status_i) == 3'b011) |=> !(|strb));

  p_den_match_r7: assert property (@(posedge clk) disable iff (rst)
    den_o == (|strb));

  p_dt_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (|strb) |-> $stable(dt_tx_o));

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));

endmodule

bind status_cmd_decoder status_cmd_decoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .status_i (status_i),
  .ale_o    (ale_o),
  .mem_rd_o (mem_rd_o),
  .mem_wr_o (mem_wr_o),
  .io_rd_o  (io_rd_o),
  .io_wr_o  (io_wr_o),
  .inta_o   (inta_o),
  .den_o    (den_o),
  .dt_tx_o  (dt_tx_o)
);

// File: tb/status_cmd_decoder_bench.sv
`timescale 1ns/1ps
module status_cmd_decoder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] status = 3'b111;
  logic ale, mrd, mwr, iord, iowr, inta, den, dt;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  status_cmd_decoder u_status_cmd_decoder (
    .clk(clk), .rst(rst), .status_i(status),
    .ale_o(ale), .mem_rd_o(mrd), .mem_wr_o(mwr), .io_rd_o(iord),
    .io_wr_o(iowr), .inta_o(inta), .den_o(den), .dt_tx_o(dt)
  );

  // Row: {req, status driven, expected {ale,mrd,mwr,iord,iowr,inta,den,dt}}
  localparam int NV = 39;
  localparam logic [14:0] VEC [0:NV-1] = '{
    {4'd2,  3'd7, 8'b0000_0000},
    {4'd2,  3'd5, 8'b1000_0000},  // R2 start, memory read
    {4'd3,  3'd5, 8'b0100_0010},  // R3
    {4'd4,  3'd5, 8'b0100_0010},  // R4 held
    {4'd4,  3'd7, 8'b0000_0000},  // R4 drop
    {4'd4,  3'd7, 8'b0000_0000},
    {4'd2,  3'd4, 8'b1000_0000},  // fetch
    {4'd3,  3'd4, 8'b0100_0010},  // R3 fetch as read
    {4'd4,  3'd7, 8'b0000_0000},
    {4'd8,  3'd6, 8'b1000_0001},  // R8 dt with ale
    {4'd3,  3'd6, 8'b0010_0011},
    {4'd8,  3'd6, 8'b0010_0011},
    {4'd4,  3'd7, 8'b0000_0000},
    {4'd10, 3'd1, 8'b1000_0000},  // R10 back-to-back
    {4'd3,  3'd1, 8'b0001_0010},
    {4'd4,  3'd7, 8'b0000_0000},
    {4'd10, 3'd2, 8'b1000_0001},  // R10
    {4'd3,  3'd2, 8'b0000_1011},
    {4'd7,  3'd2, 8'b0000_1011},  // R7
    {4'd4,  3'd7, 8'b0000_0000},
    {4'd2,  3'd0, 8'b1000_0000},
    {4'd3,  3'd0, 8'b0000_0110},  // R3 inta
    {4'd4,  3'd7, 8'b0000_0000},
    {4'd5,  3'd3, 8'b1000_0000},  // R5 halt
    {4'd5,  3'd3, 8'b0000_0000},
    {4'd5,  3'd3, 8'b0000_0000},
    {4'd5,  3'd7, 8'b0000_0000},
    {4'd2,  3'd5, 8'b1000_0000},
    {4'd6,  3'd6, 8'b0100_0010},  // R6 change ignored
    {4'd6,  3'd2, 8'b0100_0010},  // R6
    {4'd4,  3'd7, 8'b0000_0000},
    {4'd2,  3'd1, 8'b1000_0000},
    {4'd4,  3'd7, 8'b0001_0010},  // R4 minimum one clock
    {4'd4,  3'd7, 8'b0000_0000},
    {4'd5,  3'd3, 8'b1000_0000},
    {4'd6,  3'd5, 8'b0000_0000},  // R6 code in halt ignored
    {4'd6,  3'd5, 8'b0000_0000},
    {4'd5,  3'd7, 8'b0000_0000},
    {4'd2,  3'd7, 8'b0000_0000}
  };

  task automatic check(input int req, input logic [7:0] exp);
    logic [7:0] act;
    act = {ale, mrd, mwr, iord, iowr, inta, den, dt};
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: outputs %b, expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] st, input logic r, input int req,
                      input logic [7:0] exp);
    @(negedge clk);
    status = st;
    rst    = r;
    @(posedge clk);
    #1;
    check(req, exp);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(3'd7, 1'b1, 1, 8'b0);
    // R1: code present during reset causes nothing
    step(3'd5, 1'b1, 1, 8'b0);
    step(3'd7, 1'b0, 1, 8'b0);

    for (int i = 0; i < NV; i++)
      step(VEC[i][10:8], 1'b0, int'(VEC[i][14:11]), VEC[i][7:0]);

    // R1: reset in the middle of a write command
    step(3'd6, 1'b0, 2, 8'b1000_0001);
    step(3'd6, 1'b0, 3, 8'b0010_0011);
    step(3'd6, 1'b1, 1, 8'b0000_0000);
    step(3'd7, 1'b0, 1, 8'b0000_0000);
    // recovery: R2 start after reset
    step(3'd2, 1'b0, 2, 8'b1000_0001);
    step(3'd2, 1'b0, 3, 8'b0000_1011);
    step(3'd7, 1'b0, 4, 8'b0000_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule